// File: doc/BRIEF.md
# Gated Acquisition Trigger Controller

This block decides the clock cycle in which the data-acquisition path begins to sample. It watches two lines. The first is a readiness line that says the measurement system is armed. The second is the output of the first pulse generator, called the pulse line here. From these it issues a one-cycle start strobe for every subpoint conversion. A conversion occupies the converter for a fixed number of cycles, and the block keeps count of subpoints, points and sweeps.

The same qualified trigger can start different amounts of work, depending on the sweep mode:

- one data point;
- every subpoint of an averaged point;
- a single subpoint of an averaged point;
- a whole continuous-wave sweep.

A pulse edge that arrives while the system is not ready is dropped and is not remembered. When the trigger source is internal, the readiness line is taken as always true. When pulse synchronisation is turned off, the readiness line itself is the trigger.

A host sets the mode, the point count and the subpoint count while the block is idle. It then watches the done strobes and the running indices.

Top module: `acq_trig_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, acq_start_o, busy_o, point_done_o and sweep_done_o are low, and both indices are zero.
- R2: Setup is sync enabled, source external and the block idle. If p0_i is sampled high at a clock edge, was low at the edge before, and meas_trig_i is high at that same edge, then acq_start_o is high for exactly the following cycle and busy_o rises with it.
- R3: With the source external and sync enabled, a p0_i rising edge that is sampled while meas_trig_i is low starts nothing. Raising meas_trig_i afterwards, while p0_i stays high, also starts nothing. Only a later fresh p0_i edge starts a conversion.
- R4: With the source internal (src_ext_i = 0), meas_trig_i is ignored, and every p0_i rising edge seen while idle starts a conversion.
- R5: Each conversion keeps busy_o high for exactly CONV_CYCLES cycles, whatever the width of the p0_i pulse.
- R6: With sync disabled, p0_i has no effect. With an external source, a conversion starts on a rising edge of meas_trig_i. With an internal source, conversions start repeatedly whenever the block is idle.
- R7: Mode 2'b00 (step): each trigger acquires one subpoint, raises point_done_o for one cycle and returns to idle. num_subpts_i is ignored.
- R8: Mode 2'b01 (average, one trigger): one trigger acquires num_subpts_i subpoints back to back, each with its own start strobe, followed by one point_done_o.
- R9: Mode 2'b10 (average, trigger per subpoint): each subpoint needs its own trigger, and point_done_o follows the last subpoint only.
- R10: Mode 2'b11 (continuous wave): one trigger acquires all num_points_i points back to back, with one subpoint each.
- R11: A trigger that arrives while busy_o is high is discarded. It neither extends nor queues a conversion.
- R12: sweep_done_o pulses in the same cycle as the point_done_o of the last point, and both indices then read zero. A point or subpoint count of zero acts as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_trig_i | input | 1 | Measurement-ready / armed line |
| p0_i | input | 1 | Pulse generator output used as trigger |
| p0_sync_en_i | input | 1 | 1: synchronise acquisition to p0_i edges |
| src_ext_i | input | 1 | 1: external trigger source, 0: internal (ready forced true) |
| mode_i | input | 2 | Sweep mode: 00 step, 01 average one trigger, 10 average per-subpoint trigger, 11 continuous wave |
| num_points_i | input | PT_W | Points per sweep |
| num_subpts_i | input | SUB_W | Subpoints per point in the averaging modes |
| acq_start_o | output | 1 | One-cycle strobe at the start of each subpoint conversion |
| busy_o | output | 1 | Conversion in progress |
| point_done_o | output | 1 | One-cycle strobe after the last subpoint of a point |
| sweep_done_o | output | 1 | One-cycle strobe after the last point of a sweep |
| point_idx_o | output | PT_W | Index of the current point |
| sub_idx_o | output | SUB_W | Index of the current subpoint |

## Verification
The hardest case to reach is a pulse edge that is rejected and must stay forgotten. The bench raises p0_i while meas_trig_i is low, holds p0_i high, and only then raises meas_trig_i. A design that stored the edge, or that used level detection, would start a conversion at that point. The bench also sends a second pulse edge in the middle of a conversion to show it is not queued. Every mode is driven from a table of counts and trigger totals, and the strobes that come out are tallied.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

   typedef enum logic [1:0] {
      ACQ_STEP     = 2'b00,
      ACQ_AVG_ONE  = 2'b01,
      ACQ_AVG_EACH = 2'b10,
      ACQ_CW       = 2'b11
   } acq_mode_e;

   function automatic logic mode_chains_subpts(acq_mode_e m);
      return m == ACQ_AVG_ONE;
   endfunction

   function automatic logic mode_averages(acq_mode_e m);
      return (m == ACQ_AVG_ONE) || (m == ACQ_AVG_EACH);
   endfunction

endpackage

// File: rtl/acq_trig_qual.sv
module acq_trig_qual #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic meas_i,
   input  logic p0_i,
   input  logic sync_en_i,
   input  logic src_ext_i,
   output logic trig_o
);

   logic meas_s;
   logic p0_s;
   logic meas_prev;
   logic p0_prev;
   logic ready;
   logic p0_rise;
   logic meas_rise;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_stages
         $error("acq_trig_qual: SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign meas_s = meas_i;
         assign p0_s   = p0_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] meas_chain;
         logic [SYNC_STAGES-1:0] p0_chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meas_chain <= '0;
               p0_chain   <= '0;
            end else begin
               meas_chain[0] <= meas_i;
               p0_chain[0]   <= p0_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  meas_chain[i] <= meas_chain[i-1];
                  p0_chain[i]   <= p0_chain[i-1];
               end
            end
         end
         assign meas_s = meas_chain[SYNC_STAGES-1];
         assign p0_s   = p0_chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meas_prev <= 1'b0;
         p0_prev   <= 1'b0;
      end else begin
         meas_prev <= meas_s;
         p0_prev   <= p0_s;
      end
   end

   always_comb begin
      ready     = src_ext_i ? meas_s : 1'b1;
      p0_rise   = p0_s & ~p0_prev;
      meas_rise = meas_s & ~meas_prev;
      if (sync_en_i) begin
         trig_o = p0_rise & ready;
      end else if (src_ext_i) begin
         trig_o = meas_rise;
      end else begin
         trig_o = 1'b1;
      end
   end

endmodule

// File: rtl/acq_conv_timer.sv
module acq_conv_timer #(
   parameter int CONV_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   output logic busy_o,
   output logic done_o
);

   localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

   logic [CNT_W-1:0] cnt;
   logic             run;

   generate
      if (CONV_CYCLES < 2) begin : g_bad_len
         $error("acq_conv_timer: CONV_CYCLES must be at least 2");
      end
   endgenerate

   assign done_o = run && (cnt == LAST);
   assign busy_o = run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (launch_i) begin
         run <= 1'b1;
         cnt <= '0;
      end else if (done_o) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (run) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/acq_seq.sv
module acq_seq
   import acq_trig_pkg::*;
#(
   parameter int PT_W  = 16,
   parameter int SUB_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             busy_i,
   input  logic             conv_done_i,
   input  logic [1:0]       mode_i,
   input  logic [PT_W-1:0]  num_points_i,
   input  logic [SUB_W-1:0] num_subpts_i,
   output logic             launch_o,
   output logic             start_o,
   output logic             point_done_o,
   output logic             sweep_done_o,
   output logic [PT_W-1:0]  point_idx_o,
   output logic [SUB_W-1:0] sub_idx_o
);

   acq_mode_e        mode;
   logic             last_sub;
   logic             last_pt;
   logic             chain;
   logic [PT_W:0]    pt_next;
   logic [SUB_W:0]   sub_next;

   assign mode     = acq_mode_e'(mode_i);
   assign pt_next  = {1'b0, point_idx_o} + 1'b1;
   assign sub_next = {1'b0, sub_idx_o} + 1'b1;

   always_comb begin
      last_pt  = pt_next >= {1'b0, num_points_i};
      last_sub = mode_averages(mode) ? (sub_next >= {1'b0, num_subpts_i}) : 1'b1;
      chain    = conv_done_i &&
                 ((!last_sub && mode_chains_subpts(mode)) ||
                  (last_sub && !last_pt && mode == ACQ_CW));
      launch_o = (!busy_i && trig_i) || chain;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o      <= 1'b0;
         point_done_o <= 1'b0;
         sweep_done_o <= 1'b0;
         point_idx_o  <= '0;
         sub_idx_o    <= '0;
      end else begin
         start_o      <= launch_o;
         point_done_o <= conv_done_i && last_sub;
         sweep_done_o <= conv_done_i && last_sub && last_pt;
         if (conv_done_i) begin
            if (!last_sub) begin
               sub_idx_o <= sub_next[SUB_W-1:0];
            end else begin
               sub_idx_o <= '0;
               if (last_pt) begin
                  point_idx_o <= '0;
               end else begin
                  point_idx_o <= pt_next[PT_W-1:0];
               end
            end
         end
      end
   end

endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl #(
   parameter int PT_W        = 16,
   parameter int SUB_W       = 10,
   parameter int CONV_CYCLES = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             meas_trig_i,
   input  logic             p0_i,
   input  logic             p0_sync_en_i,
   input  logic             src_ext_i,
   input  logic [1:0]       mode_i,
   input  logic [PT_W-1:0]  num_points_i,
   input  logic [SUB_W-1:0] num_subpts_i,
   output logic             acq_start_o,
   output logic             busy_o,
   output logic             point_done_o,
   output logic             sweep_done_o,
   output logic [PT_W-1:0]  point_idx_o,
   output logic [SUB_W-1:0] sub_idx_o
);

   logic trig;
   logic launch;
   logic conv_done;

   generate
      if (PT_W < 1 || SUB_W < 1) begin : g_bad_width
         $error("acq_trig_ctrl: index widths must be at least 1");
      end
   endgenerate

   acq_trig_qual #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .meas_i    (meas_trig_i),
      .p0_i      (p0_i),
      .sync_en_i (p0_sync_en_i),
      .src_ext_i (src_ext_i),
      .trig_o    (trig)
   );

   acq_conv_timer #(
      .CONV_CYCLES (CONV_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .busy_o   (busy_o),
      .done_o   (conv_done)
   );

   acq_seq #(
      .PT_W  (PT_W),
      .SUB_W (SUB_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig_i       (trig),
      .busy_i       (busy_o),
      .conv_done_i  (conv_done),
      .mode_i       (mode_i),
      .num_points_i (num_points_i),
      .num_subpts_i (num_subpts_i),
      .launch_o     (launch),
      .start_o      (acq_start_o),
      .point_done_o (point_done_o),
      .sweep_done_o (sweep_done_o),
      .point_idx_o  (point_idx_o),
      .sub_idx_o    (sub_idx_o)
   );

endmodule

// File: rtl/acq_trig_chk.sv
module acq_trig_chk #(
   parameter int PT_W        = 16,
   parameter int SUB_W       = 10,
   parameter int SYNC_STAGES = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             meas_trig_i,
   input logic             p0_i,
   input logic             p0_sync_en_i,
   input logic             src_ext_i,
   input logic [1:0]       mode_i,
   input logic             acq_start_o,
   input logic             busy_o,
   input logic             point_done_o,
   input logic             sweep_done_o,
   input logic [PT_W-1:0]  point_idx_o,
   input logic [SUB_W-1:0] sub_idx_o
);

   logic p0_d1, p0_d2, meas_d1, busy_d1, sync_d1, ext_d1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p0_d1   <= 1'b0;
         p0_d2   <= 1'b0;
         meas_d1 <= 1'b0;
         busy_d1 <= 1'b0;
         sync_d1 <= 1'b0;
         ext_d1  <= 1'b0;
      end else begin
         p0_d1   <= p0_i;
         p0_d2   <= p0_d1;
         meas_d1 <= meas_trig_i;
         busy_d1 <= busy_o;
         sync_d1 <= p0_sync_en_i;
         ext_d1  <= src_ext_i;
      end
   end

   // R2: a conversion never runs without having been started
   assert_busy_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> acq_start_o);

   // R5: the start strobe always falls inside a conversion
   assert_start_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acq_start_o |-> busy_o);

   // R11: strobes are never back to back (conversions last at least two cycles)
   assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acq_start_o |=> !acq_start_o);

   // R12: sweep end coincides with point end and clears the indices
   assert_sweep_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done_o |-> (point_done_o && point_idx_o == '0 && sub_idx_o == '0));

   // R7: in step mode the block is idle once a point completes
   assert_step_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (point_done_o && mode_i == 2'b00) |-> !busy_o);

   generate
      if (SYNC_STAGES == 0) begin : g_edge_chk
         // R3: a start out of idle in synced external mode needs a ready, fresh p0 edge
         assert_qualified_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (acq_start_o && !busy_d1 && sync_d1 && ext_d1) |-> (p0_d1 && !p0_d2 && meas_d1));
      end
   endgenerate

endmodule

bind acq_trig_ctrl acq_trig_chk #(
   .PT_W        (PT_W),
   .SUB_W       (SUB_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_acq_trig_ctrl.sv
module sim_acq_trig_ctrl;

   localparam int PT_W  = 8;
   localparam int SUB_W = 4;
   localparam int CONV  = 4;
   localparam int N_VEC = 9;
   // fields: req, mode, npts, nsub, ntrig, exp_start, exp_point_done, exp_sweep_done
   localparam int VEC [N_VEC][8] = '{
      '{7,  0, 3, 3, 2, 2, 2, 0},   // R7 step, subpoint count ignored
      '{7,  0, 2, 1, 2, 2, 2, 1},   // R7 step, full sweep
      '{8,  1, 2, 3, 2, 6, 2, 1},   // R8 one trigger per averaged point
      '{9,  2, 1, 3, 3, 3, 1, 1},   // R9 one trigger per subpoint
      '{9,  2, 2, 2, 2, 2, 1, 0},   // R9 partial sweep
      '{10, 3, 4, 2, 1, 4, 4, 1},   // R10 one trigger, whole sweep
      '{10, 3, 3, 1, 2, 6, 6, 2},   // R10 two sweeps
      '{12, 0, 0, 1, 1, 1, 1, 1},   // R12 zero points acts as one
      '{12, 1, 1, 0, 1, 1, 1, 1}    // R12 zero subpoints acts as one
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic meas = 1'b0, p0 = 1'b0, sync_en = 1'b1, src_ext = 1'b1;
   logic [1:0] mode = 2'b00;
   logic [PT_W-1:0] npts = 8'd1;
   logic [SUB_W-1:0] nsub = 4'd1;
   logic acq_start, busy, pdone, sdone;
   logic [PT_W-1:0] pidx;
   logic [SUB_W-1:0] sidx;

   int checks = 0, fails = 0;
   int n_start = 0, n_pd = 0, n_sd = 0, n_busy = 0, n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   acq_trig_ctrl #(.PT_W(PT_W), .SUB_W(SUB_W), .CONV_CYCLES(CONV), .SYNC_STAGES(0)) u0 (
      .clk(clk), .rst_n(rst_n), .meas_trig_i(meas), .p0_i(p0),
      .p0_sync_en_i(sync_en), .src_ext_i(src_ext), .mode_i(mode),
      .num_points_i(npts), .num_subpts_i(nsub),
      .acq_start_o(acq_start), .busy_o(busy), .point_done_o(pdone),
      .sweep_done_o(sdone), .point_idx_o(pidx), .sub_idx_o(sidx));

   always @(negedge clk) begin
      if (rst_n) begin
         n_start = n_start + int'(acq_start);
         n_pd    = n_pd + int'(pdone);
         n_sd    = n_sd + int'(sdone);
         n_busy  = n_busy + int'(busy);
         if (sdone && !pdone) n_bad = n_bad + 1;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clr;
      @(posedge clk); #1;
      n_start = 0; n_pd = 0; n_sd = 0; n_busy = 0; n_bad = 0;
      @(negedge clk);
   endtask

   task automatic do_reset;
      @(negedge clk); rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
   endtask

   task automatic pulse_p0(int hold);
      p0 = 1'b1; tick(hold); p0 = 1'b0; tick(1);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      // R1: reset state
      tick(2);
      chk("R1 start in reset", int'(acq_start), 0);
      chk("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1; tick(1);
      chk("R1 flags after reset", int'({pdone, sdone}), 0);
      chk("R1 indices after reset", int'(pidx) + int'(sidx), 0);

      // table of modes
      for (int v = 0; v < N_VEC; v++) begin
         mode = VEC[v][1][1:0]; npts = VEC[v][2][PT_W-1:0]; nsub = VEC[v][3][SUB_W-1:0];
         sync_en = 1'b1; src_ext = 1'b1; meas = 1'b1;
         do_reset(); clr();
         for (int t = 0; t < VEC[v][4]; t++) begin
            pulse_p0(2); tick(26);
         end
         chk($sformatf("R%0d vec%0d starts", VEC[v][0], v), n_start, VEC[v][5]);
         chk($sformatf("R%0d vec%0d point_done", VEC[v][0], v), n_pd, VEC[v][6]);
         chk($sformatf("R%0d vec%0d sweep_done", VEC[v][0], v), n_sd, VEC[v][7]);
         chk($sformatf("R%0d vec%0d busy cycles", VEC[v][0], v), n_busy, VEC[v][5] * CONV);
         chk("R12 sweep_done without point_done", n_bad, 0);
      end

      // R2: strobe timing
      mode = 2'b00; npts = 8'd4; meas = 1'b1; sync_en = 1'b1; src_ext = 1'b1;
      do_reset(); clr();
      p0 = 1'b1; tick(1);
      chk("R2 start after edge", int'(acq_start), 1);
      chk("R2 busy with start", int'(busy), 1);
      tick(1);
      chk("R2 strobe one cycle", int'(acq_start), 0);
      p0 = 1'b0; tick(10);

      // R5: pulse width has no effect on busy length
      clr(); pulse_p0(1); tick(12);
      chk("R5 busy short pulse", n_busy, CONV);
      clr(); pulse_p0(12); tick(4);
      chk("R5 busy long pulse", n_busy, CONV);

      // R3: edge while not ready is forgotten
      clr(); meas = 1'b0; p0 = 1'b1; tick(3); meas = 1'b1; tick(8);
      chk("R3 stale edge ignored", n_start, 0);
      p0 = 1'b0; tick(1); p0 = 1'b1; tick(1);
      chk("R3 fresh edge starts", int'(acq_start), 1);
      p0 = 1'b0; tick(8);
      clr(); meas = 1'b0; tick(1); meas = 1'b1; p0 = 1'b1; tick(1);
      chk("R3 same-edge ready starts", int'(acq_start), 1);
      p0 = 1'b0; tick(8);

      // R4: internal source ignores meas
      clr(); src_ext = 1'b0; meas = 1'b0; pulse_p0(2); tick(8);
      chk("R4 internal source starts", n_start, 1);

      // R11: trigger during busy is dropped
      src_ext = 1'b1; meas = 1'b1; mode = 2'b00; npts = 8'd8;
      do_reset(); clr();
      pulse_p0(1); pulse_p0(1); tick(12);
      chk("R11 busy trigger dropped", n_start, 1);
      pulse_p0(1); tick(8);
      chk("R11 idle trigger accepted", n_start, 2);

      // R6: sync disabled
      sync_en = 1'b0; src_ext = 1'b1; meas = 1'b0;
      do_reset(); clr();
      pulse_p0(2); tick(8);
      chk("R6 p0 ignored when unsynced", n_start, 0);
      meas = 1'b1; tick(1);
      chk("R6 meas rise starts", int'(acq_start), 1);
      tick(10);
      chk("R6 meas level starts once", n_start, 1);
      src_ext = 1'b0; npts = 8'd100; clr(); tick(30);
      chk("R6 internal free-run", int'(n_start >= 5), 1);

      // R12: indices return to zero after a CW sweep
      sync_en = 1'b1; src_ext = 1'b1; meas = 1'b1; mode = 2'b11; npts = 8'd3;
      do_reset(); clr();
      pulse_p0(1); tick(4);
      chk("R10 point index advances", int'(pidx), 1);
      tick(16);
      chk("R12 sweep done once", n_sd, 1);
      chk("R12 index cleared", int'(pidx) + int'(sidx), 0);

      finish_run();
   end

endmodule